// File: doc/BRIEF.md
# Slow-Clock Watchdog with Prescaler and Key Interface

This block is a watchdog that counts on a slow oscillator of its own rather than on the system clock. It therefore keeps counting while the rest of the chip sleeps in a stop or standby state. A prescaler with a selectable division drives a 12-bit down-counter. When that counter runs out, the block raises a reset request to the reset controller. The request stays high until the block itself is reset.

Software controls the watchdog through write-only registers in the bus clock domain. The key register holds three special values:
- one value starts the watchdog;
- one value reloads (feeds) it;
- one value opens the prescaler and reload registers for writing.

Every other value written to the key register closes those two registers again. A strap input sampled during reset can start the watchdog with no software action. A debug-halt input freezes counting while a debugger has the processor stopped.

Start and feed commands cross into the watchdog clock domain through a toggle handshake. Each command carries a snapshot of the prescaler and reload settings with it, so no multi-bit setting ever crosses the clock boundary on its own. Once started, the watchdog cannot be stopped. Only `rst` stops it.

Top module: `slow_clk_watchdog`

## Requirements
- R1: After `rst` with `hw_start` low, the watchdog stays idle. `rst_req` is low and stays low however long `wd_clk` runs, as long as no start key is written.
- R2: If `hw_start` is high during `rst`, counting begins when reset is released. It starts from reload value 0xFFF with divide-by-4, so `rst_req` rises 16384 `wd_clk` cycles after release.
- R3: Writing 0xCCCC to the key register (`wr_sel` = 0) loads the counter with the current reload value R, loads the prescaler with the current division D, and starts counting. `rst_req` rises (R+1)·D `wd_clk` cycles after the command is applied in the watchdog domain.
- R4: Writing 0xAAAA to the key register reloads the counter and restarts the prescaler. Feeding more often than the timeout keeps `rst_req` low indefinitely.
- R5: Once counting has begun, no key value stops it. Only `rst` does.
- R6: The prescaler code is `wr_data[2:0]`, written at `wr_sel` = 1. Code n gives D = 4·2^n for n = 0 to 6. Codes 6 and 7 both give D = 256. The reset code is 0.
- R7: The reload value is `wr_data[11:0]`, written at `wr_sel` = 2. Its reset value is 0xFFF. `wr_sel` = 3 is ignored.
- R8: Writes at `wr_sel` 1 and 2 take effect only while the registers are open. They are open when the last key written was 0x5555. Any other key value closes them, and reset leaves them closed.
- R9: While `dbg_halt` is high, the counter and prescaler hold their values. `dbg_halt` is synchronous to `wd_clk`. When it is released, counting resumes from where it stopped.
- R10: Once `rst_req` is high, it stays high until `rst`.
- R11: A start or feed key write is applied in the watchdog domain within 6 `wd_clk` cycles of the bus write. Keys written while a transfer is in flight are merged and sent as the next transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus-side register clock |
| wd_clk | input | 1 | Independent slow watchdog clock |
| rst | input | 1 | Synchronous active-high reset; must be held for at least 3 `wd_clk` cycles |
| hw_start | input | 1 | Hardware-start strap, sampled during reset |
| dbg_halt | input | 1 | Debug freeze, synchronous to `wd_clk` |
| wr_en | input | 1 | Register write strobe (`bus_clk`) |
| wr_sel | input | 2 | Register select: 0 key, 1 prescaler, 2 reload |
| wr_data | input | 16 | Write data |
| rst_req | output | 1 | Reset request to the reset controller (`wd_clk` domain) |

## Verification
The timeout is measured in `wd_clk` cycles from the command to the rise of `rst_req`. Several prescaler and reload pairs are used: code 0 with reload 3, code 2 with reload 3, code 3 with reload 0, and codes 6 and 7 with reload 1. These pairs separate a wrong division, an off-by-one in the terminal count, and a wrong saturation of the high codes. The strap run from reset checks the full default period.

Register writes made while the registers are closed, and writes made after they have been closed again, should leave a timeout that exposes which reload value was used. A sequence of periodic feeds, followed by stopping the feeds, shows that feeding restarts the count. A long halt followed by release shows that the halt froze the count rather than restarting it.

// File: rtl/swd_pkg.sv
package swd_pkg;

    localparam int unsigned CNT_W     = 12;
    localparam int unsigned PSC_W     = 3;
    localparam int unsigned DIV_W     = 8;
    localparam int unsigned KEY_W     = 16;
    localparam int unsigned SEL_W     = 2;
    localparam int unsigned MAX_SHIFT = 6;

    localparam logic [KEY_W-1:0] KEY_OPEN = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_FEED = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_RUN  = 16'hCCCC;

    typedef enum logic [SEL_W-1:0] {
        SEL_KEY  = 2'd0,
        SEL_PSC  = 2'd1,
        SEL_RLD  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    // Command carried across the clock boundary with its settings snapshot
    typedef struct packed {
        logic             run;
        logic             feed;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] rld;
    } cmd_t;

    // Terminal prescaler count for a code: (4 << min(code, MAX_SHIFT)) - 1
    function automatic logic [DIV_W-1:0] div_last(input logic [PSC_W-1:0] code);
        logic [PSC_W-1:0] sh;
        logic [DIV_W:0]   d;
        sh = (code > PSC_W'(MAX_SHIFT)) ? PSC_W'(MAX_SHIFT) : code;
        d  = (DIV_W+1)'(4) << sh;
        return DIV_W'(d - 1'b1);
    endfunction

endpackage

// File: rtl/swd_regs.sv
module swd_regs
    import swd_pkg::*;
#(
    parameter logic [CNT_W-1:0] RLD_INIT = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [KEY_W-1:0] wr_data,
    output logic             run_p,
    output logic             feed_p,
    output logic [PSC_W-1:0] psc_q,
    output logic [CNT_W-1:0] rld_q
);

    sel_e sel;
    logic key_wr;
    logic open_q;

    assign sel    = sel_e'(wr_sel);
    assign key_wr = wr_en && (sel == SEL_KEY);
    assign run_p  = key_wr && (wr_data == KEY_RUN);
    assign feed_p = key_wr && (wr_data == KEY_FEED);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            psc_q  <= '0;
            rld_q  <= RLD_INIT;
        end else begin
            if (key_wr) begin
                open_q <= (wr_data == KEY_OPEN);
            end
            if (wr_en && open_q && (sel == SEL_PSC)) begin
                psc_q <= wr_data[PSC_W-1:0];
            end
            if (wr_en && open_q && (sel == SEL_RLD)) begin
                rld_q <= wr_data[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/swd_xfer.sv
module swd_xfer
    import swd_pkg::*;
#(
    parameter int unsigned SYNC_N = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst,
    input  logic             run_p,
    input  logic             feed_p,
    input  logic [PSC_W-1:0] psc_in,
    input  logic [CNT_W-1:0] rld_in,
    input  logic             wd_clk,
    input  logic             wd_rst,
    output logic             cmd_v,
    output cmd_t             cmd_q
);

    // ---------------- bus side ----------------
    logic              req_q;
    logic              pend_run;
    logic              pend_feed;
    cmd_t              hold_q;
    logic [SYNC_N-1:0] ack_sync;
    logic              ack_q;
    logic              busy;
    logic              want_run;
    logic              want_feed;
    logic              launch;

    assign busy      = req_q != ack_sync[SYNC_N-1];
    assign want_run  = pend_run  | run_p;
    assign want_feed = pend_feed | feed_p;
    assign launch    = !busy && (want_run || want_feed);

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            req_q     <= 1'b0;
            pend_run  <= 1'b0;
            pend_feed <= 1'b0;
            hold_q    <= '0;
            ack_sync  <= '0;
        end else begin
            ack_sync <= {ack_sync[SYNC_N-2:0], ack_q};
            if (launch) begin
                req_q       <= ~req_q;
                hold_q.run  <= want_run;
                hold_q.feed <= want_feed;
                hold_q.psc  <= psc_in;
                hold_q.rld  <= rld_in;
                pend_run    <= 1'b0;
                pend_feed   <= 1'b0;
            end else begin
                pend_run  <= want_run;
                pend_feed <= want_feed;
            end
        end
    end

    // ---------------- watchdog side ----------------
    logic [SYNC_N-1:0] req_sync;

    always_ff @(posedge wd_clk) begin
        if (wd_rst) begin
            req_sync <= '0;
            ack_q    <= 1'b0;
            cmd_v    <= 1'b0;
            cmd_q    <= '0;
        end else begin
            req_sync <= {req_sync[SYNC_N-2:0], req_q};
            cmd_v    <= 1'b0;
            if (req_sync[SYNC_N-1] != ack_q) begin
                ack_q <= req_sync[SYNC_N-1];
                cmd_v <= 1'b1;
                cmd_q <= hold_q;
            end
        end
    end

endmodule

// File: rtl/swd_core.sv
module swd_core
    import swd_pkg::*;
#(
    parameter logic [CNT_W-1:0] RLD_INIT = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_start,
    input  logic             freeze,
    input  logic             cmd_v,
    input  cmd_t             cmd,
    output logic [CNT_W-1:0] cnt_q,
    output logic             running_q,
    output logic             expired_q
);

    logic [PSC_W-1:0] code_q;
    logic [DIV_W-1:0] pcnt_q;
    logic             advance;
    logic             tick;

    assign advance = running_q && !freeze && !expired_q;
    assign tick    = advance && (pcnt_q == div_last(code_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= hw_start;
            cnt_q     <= RLD_INIT;
            code_q    <= '0;
            pcnt_q    <= '0;
            expired_q <= 1'b0;
        end else if (cmd_v) begin
            cnt_q  <= cmd.rld;
            code_q <= cmd.psc;
            pcnt_q <= '0;
            if (cmd.run) begin
                running_q <= 1'b1;
            end
        end else if (tick) begin
            pcnt_q <= '0;
            if (cnt_q == '0) begin
                expired_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (advance) begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/slow_clk_watchdog.sv
module slow_clk_watchdog
    import swd_pkg::*;
#(
    parameter int unsigned      SYNC_N   = 2,
    parameter logic [CNT_W-1:0] RLD_INIT = '1
) (
    input  logic             bus_clk,
    input  logic             wd_clk,
    input  logic             rst,
    input  logic             hw_start,
    input  logic             dbg_halt,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [KEY_W-1:0] wr_data,
    output logic             rst_req
);

    logic             run_p;
    logic             feed_p;
    logic [PSC_W-1:0] psc_q;
    logic [CNT_W-1:0] rld_q;
    logic             cmd_v;
    cmd_t             cmd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             running_q;

    swd_regs #(.RLD_INIT(RLD_INIT)) i_regs (
        .clk    (bus_clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .run_p  (run_p),
        .feed_p (feed_p),
        .psc_q  (psc_q),
        .rld_q  (rld_q)
    );

    swd_xfer #(.SYNC_N(SYNC_N)) i_xfer (
        .bus_clk(bus_clk),
        .bus_rst(rst),
        .run_p  (run_p),
        .feed_p (feed_p),
        .psc_in (psc_q),
        .rld_in (rld_q),
        .wd_clk (wd_clk),
        .wd_rst (rst),
        .cmd_v  (cmd_v),
        .cmd_q  (cmd_q)
    );

    swd_core #(.RLD_INIT(RLD_INIT)) i_core (
        .clk      (wd_clk),
        .rst      (rst),
        .hw_start (hw_start),
        .freeze   (dbg_halt),
        .cmd_v    (cmd_v),
        .cmd      (cmd_q),
        .cnt_q    (cnt_q),
        .running_q(running_q),
        .expired_q(rst_req)
    );

endmodule

// File: rtl/swd_chk.sv
module swd_chk
    import swd_pkg::*;
(
    input logic             bus_clk,
    input logic             wd_clk,
    input logic             rst,
    input logic             dbg_halt,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic [PSC_W-1:0] psc_q,
    input logic             cmd_v,
    input logic [CNT_W-1:0] cnt_q,
    input logic             running_q,
    input logic             rst_req
);

    AST_REQ_STICKY: assert property (@(posedge wd_clk) disable iff (rst)
        rst_req |=> rst_req);                                              // R10

    AST_NEVER_STOPS: assert property (@(posedge wd_clk) disable iff (rst)
        running_q |=> running_q);                                          // R5

    AST_EXPIRE_AT_ZERO: assert property (@(posedge wd_clk) disable iff (rst)
        $rose(rst_req) |-> (cnt_q == '0));                                 // R3

    AST_STEP_BY_ONE: assert property (@(posedge wd_clk) disable iff (rst)
        !cmd_v |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1)); // R3

    AST_HALT_FREEZES: assert property (@(posedge wd_clk) disable iff (rst)
        (dbg_halt && !cmd_v) |=> $stable(cnt_q));                          // R9

    AST_IDLE_HOLDS: assert property (@(posedge wd_clk) disable iff (rst)
        (!running_q && !cmd_v) |=> $stable(cnt_q));                        // R1

    AST_PSC_ONLY_BY_WRITE: assert property (@(posedge bus_clk) disable iff (rst)
        !(wr_en && wr_sel == SEL_PSC) |=> $stable(psc_q));                 // R8

endmodule

bind slow_clk_watchdog swd_chk i_chk (.*);

// File: tb/test_slow_clk_watchdog.sv
module test_slow_clk_watchdog;
    import swd_pkg::*;

    localparam int BUS_HALF  = 5;
    localparam int WD_HALF   = 11;
    localparam int WD_LIMIT  = 60000;

    logic             bus_clk = 1'b0;
    logic             wd_clk  = 1'b0;
    logic             rst     = 1'b1;
    logic             hw_start = 1'b0;
    logic             dbg_halt = 1'b0;
    logic             wr_en   = 1'b0;
    logic [SEL_W-1:0] wr_sel  = '0;
    logic [KEY_W-1:0] wr_data = '0;
    logic             rst_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    slow_clk_watchdog i_slow_clk_watchdog (
        .bus_clk (bus_clk),
        .wd_clk  (wd_clk),
        .rst     (rst),
        .hw_start(hw_start),
        .dbg_halt(dbg_halt),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rst_req (rst_req)
    );

    initial forever #(BUS_HALF) bus_clk = ~bus_clk;
    initial begin
        #3;
        forever #(WD_HALF) wd_clk = ~wd_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_win(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic do_reset(input bit strap);
        rst      = 1'b1;
        hw_start = strap;
        dbg_halt = 1'b0;
        wr_en    = 1'b0;
        repeat (4) @(posedge wd_clk);
        #2 rst = 1'b0;
    endtask

    task automatic bw(input logic [SEL_W-1:0] sel, input logic [KEY_W-1:0] data);
        @(posedge bus_clk);
        #2;
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(posedge bus_clk);
        #2 wr_en = 1'b0;
    endtask

    task automatic wait_req(input int lim, output int n);
        n = 0;
        while (n < lim && !rst_req) begin
            @(negedge wd_clk);
            n++;
        end
    endtask

    task automatic setup_run(input logic [PSC_W-1:0] code, input logic [CNT_W-1:0] rld);
        do_reset(1'b0);
        bw(SEL_KEY, KEY_OPEN);
        bw(SEL_PSC, KEY_W'(code));
        bw(SEL_RLD, KEY_W'(rld));
        bw(SEL_KEY, KEY_RUN);
    endtask

    // R1: idle after reset without strap
    task automatic t_idle();
        int n;
        do_reset(1'b0);
        @(negedge wd_clk);
        chk(rst_req == 1'b0, "R1 reset value", rst_req, 0);
        wait_req(17000, n);
        chk(rst_req == 1'b0, "R1 no expiry while idle", rst_req, 0);
    endtask

    // R2 strap start, R10 sticky request
    task automatic t_strap();
        int n;
        do_reset(1'b1);
        wait_req(17000, n);
        chk_win("R2 strap timeout", n, 16383, 16386);
        repeat (200) @(negedge wd_clk);
        chk(rst_req == 1'b1, "R10 request held", rst_req, 1);
        do_reset(1'b0);
        @(negedge wd_clk);
        chk(rst_req == 1'b0, "R10 cleared by reset", rst_req, 0);
    endtask

    // R3/R7/R11 software start with reload 3, divide 4
    task automatic t_start();
        int n;
        setup_run(3'd0, 12'd3);
        wait_req(200, n);
        chk_win("R3 R7 R11 start timeout", n, 17, 22);
    endtask

    // R6 prescaler codes
    task automatic t_psc();
        int n;
        for (int i = 0; i < 4; i++) begin
            logic [PSC_W-1:0] code;
            logic [CNT_W-1:0] rld;
            int               exp;
            case (i)
                0: begin code = 3'd2; rld = 12'd3; exp = 64;  end
                1: begin code = 3'd3; rld = 12'd0; exp = 32;  end
                2: begin code = 3'd6; rld = 12'd1; exp = 512; end
                default: begin code = 3'd7; rld = 12'd1; exp = 512; end
            endcase
            setup_run(code, rld);
            wait_req(1000, n);
            chk_win($sformatf("R6 prescaler code %0d", code), n, exp + 1, exp + 6);
        end
    endtask

    // R8 locked writes ignored, relock on other key
    task automatic t_lock();
        int n;
        do_reset(1'b0);
        bw(SEL_PSC, 16'h0002);
        bw(SEL_RLD, 16'h0003);
        bw(SEL_KEY, KEY_RUN);
        wait_req(300, n);
        chk(rst_req == 1'b0, "R8 locked writes ignored", rst_req, 0);
        do_reset(1'b0);
        bw(SEL_KEY, KEY_OPEN);
        bw(SEL_RLD, 16'h0005);
        bw(SEL_KEY, 16'h1234);
        bw(SEL_RLD, 16'h0001);
        bw(SEL_NONE, 16'h0000);
        bw(SEL_KEY, KEY_RUN);
        wait_req(300, n);
        chk_win("R8 R7 relock keeps reload 5", n, 25, 30);
    endtask

    // R4 feeding keeps it alive
    task automatic t_feed();
        int n;
        setup_run(3'd0, 12'd9);
        for (int k = 0; k < 10; k++) begin
            repeat (20) @(negedge wd_clk);
            bw(SEL_KEY, KEY_FEED);
        end
        chk(rst_req == 1'b0, "R4 fed watchdog quiet", rst_req, 0);
        wait_req(200, n);
        chk_win("R4 timeout after last feed", n, 41, 46);
    endtask

    // R5 other keys do not stop it
    task automatic t_nostop();
        int n;
        setup_run(3'd0, 12'd7);
        bw(SEL_KEY, 16'h0000);
        bw(SEL_KEY, 16'hFFFF);
        bw(SEL_KEY, KEY_OPEN);
        wait_req(200, n);
        chk(rst_req == 1'b1 && n < 40, "R5 cannot be stopped", n, 32);
    endtask

    // R9 debug halt freezes count
    task automatic t_freeze();
        int n;
        do_reset(1'b0);
        @(posedge wd_clk);
        #2 dbg_halt = 1'b1;
        bw(SEL_KEY, KEY_OPEN);
        bw(SEL_RLD, 16'h0003);
        bw(SEL_KEY, KEY_RUN);
        repeat (300) @(negedge wd_clk);
        chk(rst_req == 1'b0, "R9 halted no expiry", rst_req, 0);
        @(posedge wd_clk);
        #2 dbg_halt = 1'b0;
        wait_req(200, n);
        chk_win("R9 resume timeout", n, 15, 17);
    endtask

    initial begin
        #(WD_LIMIT * 2 * WD_HALF);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_idle();
        t_strap();
        t_start();
        t_psc();
        t_lock();
        t_feed();
        t_nostop();
        t_freeze();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule